// File: doc/BRIEF.md
# Strap Capture and Clock Output Gating

This block handles the pins of a clock generator that serve two purposes, and it gates every clock output. When the synchronous power-good input rises, a cycle counter opens a fixed sampling window. During that window every output is three-stated, so external strap resistors can set the levels on the five shared pins. When the window closes, the block captures those levels as four frequency-select bits and one mode bit, and from then on it drives the pins as clock outputs. The captured values stay put until power-good falls again.

The mode bit decides the role of one pin. With mode 1 it is a reference clock output. With mode 0 it is an active-low CPU stop input. A power-down input, the CPU stop input, a per-output disable mask and a global three-state test bit together set each output's state: three-stated, driven low, or passing its source clock. Source clocks come in as plain inputs.

Changes that come from power-down, CPU stop or the disable mask are taken on only at a clock edge where that output's source is low. This keeps runt pulses off the outputs.

Top module: `strap_clk_gate`

## Requirements
- R1: Every output is three-stated (`pin_oe` all 0) from power-good low until the WIN_CYC-th rising clock edge at which power-good is sampled high. At that edge `straps_done` goes to 1.
- R2: At the end of the window, each strap bit is captured from its pin if `strap_drv` marks that pin as driven. An undriven pin reads as 1, except the FS3 strap, which reads as 0. Strap bit order is bit0 FS0, bit1 FS1, bit2 FS2, bit3 FS3, bit4 MODE. `fs_sel` is bits 3..0 and `mode_sel` is bit 4.
- R3: Once captured, `fs_sel` and `mode_sel` ignore later changes on the strap inputs and on every other input. They are cleared only while power-good is low.
- R4: Output indices are: 0 CPU true, 1 CPU complement, 2 chipset CPU copy, 3 REF0, 4 REF1, 5 48 MHz, 6 24/48 MHz, 7 onward the PCI outputs, then the SDRAM copies. With mode 1, REF0 is driven from its source and the `stop_n` input is ignored. With mode 0, REF0 is three-stated and `stop_n` acts as the CPU stop.
- R5: While CPU stop is active (mode 0 and `stop_n` low), outputs 0 and 2 are driven low and output 1 is three-stated.
- R6: While `pd_n` is low, output 1 is three-stated and every other output, including all SDRAM copies, is driven low.
- R7: A 1 in `dis_mask[i]` drives output i low.
- R8: `tri_all` high three-states every output, overriding every low-forcing control.
- R9: A change of power-down, CPU stop or the disable mask takes effect only at a clock edge where that output's source is sampled low. While the source stays high, the output keeps following it.
- R10: With none of the controls active, each enabled output equals its source clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the window counter and the gates |
| pwr_good | input | 1 | Synchronous power-good; low clears everything |
| strap_in | input | 5 | Levels on the shared pins during the window |
| strap_drv | input | 5 | 1 where a strap resistor drives the pin |
| pd_n | input | 1 | Power-down, active low |
| stop_n | input | 1 | Level of the dual-role pin, used as CPU stop in mode 0 |
| dis_mask | input | NOUT | Per-output force-low |
| tri_all | input | 1 | Global three-state test control |
| clk_src | input | NOUT | Source clocks, one per output |
| pin_val | output | NOUT | Output levels |
| pin_oe | output | NOUT | Output drive enables |
| fs_sel | output | 4 | Captured frequency-select straps |
| mode_sel | output | 1 | Captured mode strap |
| straps_done | output | 1 | Window over, straps captured |

## Verification
The end of the window shows up on `straps_done`, `fs_sel` and `mode_sel` right after the WIN_CYC-th edge with power-good high. The bench samples these one cycle before and at that edge. A gating change needs exactly one clock edge with the source low before it shows up. After that, `pin_oe` and `pin_val` follow combinationally from the current sources. For this reason the bench applies each control with all sources low, steps one edge, raises all sources and compares the full vectors without a further edge. For R9, it also holds the sources high across several edges and checks that the outputs have not yet changed.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int IDX_CPU_T  = 0;
  localparam int IDX_CPU_C  = 1;
  localparam int IDX_CPU_CS = 2;
  localparam int IDX_REF0   = 3;
  localparam int IDX_REF1   = 4;
  localparam int IDX_USB    = 5;
  localparam int IDX_SIO    = 6;
  localparam int IDX_PCI0   = 7;
  localparam int N_STRAP    = 5;
  // pull direction of undriven strap pins: FS3 pulls down, the rest up
  localparam logic [N_STRAP-1:0] STRAP_PULL = 5'b10111;

  typedef struct packed {
    logic       mode;
    logic [3:0] fs;
  } strap_t;

  function automatic logic [N_STRAP-1:0] strap_resolve(
      input logic [N_STRAP-1:0] lvl, input logic [N_STRAP-1:0] drv);
    return (lvl & drv) | (STRAP_PULL & ~drv);
  endfunction

  function automatic logic in_cpu_group(input int idx);
    return idx <= IDX_CPU_CS;
  endfunction
endpackage

// File: rtl/scg_strap_latch.sv
module scg_strap_latch
  import scg_pkg::*;
#(
  parameter int WIN_CYC = 28636
) (
  input  logic               clk,
  input  logic               pwr_good,
  input  logic [N_STRAP-1:0] pin_lvl,
  input  logic [N_STRAP-1:0] pin_drv,
  output strap_t             straps,
  output logic               done
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt;
  logic          win_end;

  assign win_end = !done && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      cnt    <= '0;
      done   <= 1'b0;
      straps <= '0;
    end else if (win_end) begin
      done   <= 1'b1;
      straps <= strap_t'(strap_resolve(pin_lvl, pin_drv));
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    !done |-> (cnt <= LAST));
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!pwr_good)
    done |=> (done && $stable(straps)));
endmodule

// File: rtl/scg_gate_cell.sv
module scg_gate_cell #(
  parameter bit CPU_GRP = 1'b0,
  parameter bit TRI_ON_STOP = 1'b0
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic src,
  input  logic ena,
  input  logic stop_act,
  input  logic pd_n,
  input  logic dis,
  input  logic tri_all,
  output logic val,
  output logic oe
);
  logic stop_hit;
  logic live_q;
  logic run_q;

  assign stop_hit = CPU_GRP ? stop_act : 1'b0;

  // gate state only moves while the source is low
  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      live_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (!src) begin
      live_q <= pd_n & ~stop_hit;
      run_q  <= pd_n & ~stop_hit & ~dis;
    end
  end

  assign oe  = ena & ~tri_all & (TRI_ON_STOP ? live_q : 1'b1);
  assign val = oe & src & run_q;

  p_no_runt_r9: assert property (@(posedge clk) disable iff (!pwr_good)
    (src && $past(src) && $stable(oe)) |-> (val == $past(val)));
endmodule

// File: rtl/strap_clk_gate.sv
module strap_clk_gate
  import scg_pkg::*;
#(
  parameter int N_PCI   = 6,
  parameter int N_SDR   = 13,
  parameter int WIN_CYC = 28636,
  localparam int NOUT   = IDX_PCI0 + N_PCI + N_SDR
) (
  input  logic               clk,
  input  logic               pwr_good,
  input  logic [N_STRAP-1:0] strap_in,
  input  logic [N_STRAP-1:0] strap_drv,
  input  logic               pd_n,
  input  logic               stop_n,
  input  logic [NOUT-1:0]    dis_mask,
  input  logic               tri_all,
  input  logic [NOUT-1:0]    clk_src,
  output logic [NOUT-1:0]    pin_val,
  output logic [NOUT-1:0]    pin_oe,
  output logic [3:0]         fs_sel,
  output logic               mode_sel,
  output logic               straps_done
);
  strap_t straps;
  logic   stop_act;

  scg_strap_latch #(.WIN_CYC(WIN_CYC)) u_latch (
    .clk     (clk),
    .pwr_good(pwr_good),
    .pin_lvl (strap_in),
    .pin_drv (strap_drv),
    .straps  (straps),
    .done    (straps_done)
  );

  assign fs_sel   = straps.fs;
  assign mode_sel = straps.mode;
  assign stop_act = straps_done && !straps.mode && !stop_n;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic ena;
    if (i == IDX_REF0) begin : g_ref0
      assign ena = straps_done & straps.mode;
    end else begin : g_plain
      assign ena = straps_done;
    end
    scg_gate_cell #(
      .CPU_GRP    (in_cpu_group(i)),
      .TRI_ON_STOP(i == IDX_CPU_C)
    ) u_cell (
      .clk     (clk),
      .pwr_good(pwr_good),
      .src     (clk_src[i]),
      .ena     (ena),
      .stop_act(stop_act),
      .pd_n    (pd_n),
      .dis     (dis_mask[i]),
      .tri_all (tri_all),
      .val     (pin_val[i]),
      .oe      (pin_oe[i])
    );
  end

  p_window_quiet_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    !straps_done |-> (pin_oe == '0));
  p_ref0_input_r4: assert property (@(posedge clk) disable iff (!pwr_good)
    (straps_done && !mode_sel) |-> !pin_oe[IDX_REF0]);
  p_stop_tri_r5: assert property (@(posedge clk) disable iff (!pwr_good)
    (straps_done && !mode_sel && !stop_n && !clk_src[IDX_CPU_C]) |=> !pin_oe[IDX_CPU_C]);
  p_pd_low_r6: assert property (@(posedge clk) disable iff (!pwr_good)
    !pd_n |=> ((pin_val & ~$past(clk_src)) == '0));
  p_dis_low_r7: assert property (@(posedge clk) disable iff (!pwr_good)
    (dis_mask != '0) |=> ((pin_val & $past(dis_mask) & ~$past(clk_src)) == '0));
  p_tri_all_r8: assert property (@(posedge clk) disable iff (!pwr_good)
    tri_all |-> (pin_oe == '0));
endmodule

// File: tb/sim_strap_clk_gate.sv
module sim_strap_clk_gate;
  localparam int NP  = 6;
  localparam int NS  = 13;
  localparam int NO  = 7 + NP + NS;
  localparam int WIN = 8;

  logic          clk = 1'b0;
  logic          pwr_good = 1'b0;
  logic [4:0]    strap_in = '0, strap_drv = '0;
  logic          pd_n = 1'b1, stop_n = 1'b1, tri_all = 1'b0;
  logic [NO-1:0] dis_mask = '0, clk_src = '0;
  logic [NO-1:0] pin_val, pin_oe;
  logic [3:0]    fs_sel;
  logic          mode_sel, straps_done;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  strap_clk_gate #(.N_PCI(NP), .N_SDR(NS), .WIN_CYC(WIN)) u0 (
    .clk(clk), .pwr_good(pwr_good), .strap_in(strap_in), .strap_drv(strap_drv),
    .pd_n(pd_n), .stop_n(stop_n), .dis_mask(dis_mask), .tri_all(tri_all),
    .clk_src(clk_src), .pin_val(pin_val), .pin_oe(pin_oe), .fs_sel(fs_sel),
    .mode_sel(mode_sel), .straps_done(straps_done));

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic power_up(input logic [4:0] lvl, input logic [4:0] drv);
    pwr_good = 1'b0; clk_src = '0;
    step(); step();
    strap_in = lvl; strap_drv = drv; pwr_good = 1'b1;
    repeat (WIN) step();
  endtask

  // expected enables and values with every source high, settled gates
  function automatic logic [NO-1:0] exp_oe(input logic md, input logic pd, input logic sn, input logic tr);
    logic [NO-1:0] r;
    logic sa;
    sa = !md && !sn;
    for (int i = 0; i < NO; i++)
      r[i] = !tr && !(i == 3 && !md) && !(i == 1 && (!pd || sa));
    return r;
  endfunction

  function automatic logic [NO-1:0] exp_val(input logic md, input logic pd, input logic sn,
                                            input logic tr, input logic [NO-1:0] dm);
    logic [NO-1:0] oe, r;
    logic sa;
    sa = !md && !sn;
    oe = exp_oe(md, pd, sn, tr);
    for (int i = 0; i < NO; i++)
      r[i] = oe[i] && pd && !(i <= 2 && sa) && !dm[i];
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NO-1:0] dpat [4];
    dpat[0] = '0;
    dpat[1] = {(NO/2){2'b10}};
    dpat[2] = {(NO/2){2'b01}};
    dpat[3] = NO'(10);

    // R1 reset state
    step(); step();
    chk("R1 reset oe", pin_oe, '0);
    chk("R1 reset done", NO'(straps_done), '0);

    // R1 window length
    strap_in = 5'b10101; strap_drv = 5'b11111; pwr_good = 1'b1;
    clk_src = '1;
    repeat (WIN - 1) step();
    chk("R1 window done", NO'(straps_done), '0);
    chk("R1 window oe", pin_oe, '0);
    step();
    chk("R1 end done", NO'(straps_done), NO'(1));
    chk("R2 first capture", NO'({mode_sel, fs_sel}), NO'(5'b10101));

    // R3 later strap changes ignored
    strap_in = 5'b01010; strap_drv = 5'b00000;
    step(); step();
    chk("R3 hold", NO'({mode_sel, fs_sel}), NO'(5'b10101));
    pwr_good = 1'b0; step();
    chk("R3 cleared", NO'({straps_done, mode_sel, fs_sel}), '0);

    // R2 strap sweep over levels and drive masks
    for (int d = 0; d < 4; d++) begin
      for (int l = 0; l < 32; l++) begin
        logic [4:0] drv, lvl, ex;
        drv = (d == 0) ? 5'b11111 : (d == 1) ? 5'b00000 : (d == 2) ? 5'b01000 : 5'b10111;
        lvl = 5'(l);
        ex  = (lvl & drv) | (5'b10111 & ~drv);
        power_up(lvl, drv);
        chk("R2 strap", NO'({mode_sel, fs_sel}), NO'(ex));
      end
    end

    // R4..R8, R10 sweep of controls in both modes
    for (int m = 0; m < 2; m++) begin
      power_up({m[0], 4'b0011}, 5'b11111);
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 4; k++) begin
          pd_n = c[0]; stop_n = c[1]; tri_all = c[2]; dis_mask = dpat[k];
          clk_src = '0;
          step();
          chk("R6/R7 low phase", pin_val, '0);
          clk_src = '1; #1;
          chk("R4/R5/R6/R8 oe", pin_oe, exp_oe(m[0], c[0], c[1], c[2]));
          chk("R5/R6/R7/R10 val", pin_val, exp_val(m[0], c[0], c[1], c[2], dpat[k]));
          step();
        end
      end
    end

    // R9 gating waits for a low source
    power_up(5'b10000, 5'b11111);
    pd_n = 1'b1; stop_n = 1'b1; tri_all = 1'b0; dis_mask = '0;
    clk_src = '0; step(); clk_src = '1; step();
    chk("R10 run", pin_val, '1);
    pd_n = 1'b0; dis_mask = '1;
    step(); step(); step();
    chk("R9 held high val", pin_val, '1);
    chk("R9 held high oe", pin_oe, '1);
    clk_src = '0; step(); clk_src = '1; #1;
    chk("R9 applied val", pin_val, '0);
    chk("R9 applied oe", pin_oe, ~(NO'(1) << 1));
    pd_n = 1'b1; dis_mask = '0;
    step();
    chk("R9 release waits", pin_val, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule